// File: doc/BRIEF.md
# CRTC index/data register file with write lock

This block holds 256 byte-wide display-controller registers behind two bus ports: an index port and a data port. Software first writes the index port to choose a register, then reads or writes the data port to reach that register. Each port can be reached at two bus addresses, a primary and a secondary alias, and both aliases behave the same. A read of the index port returns the current selection. A read of the data port returns the selected register.

A protection bit lives in register 0x11. While it is set, data writes to the eight lowest registers are dropped. Register 7 is the one exception: its bit 4 still follows the written value. The block also raises a one-cycle update pulse after each accepted write to a horizontal or vertical timing register. A downstream timing generator can use that pulse to reload its settings.

Top module: `crtc_regs`

## Requirements
- R1: After reset the index is 0, every register is 0, `rdata_o` is 0 and `upd_o` is 0.
- R2: A write at bus address 0 or 4 (the index aliases) loads `wdata_i` into the 8-bit index. A read at either alias returns the index.
- R3: A read at bus address 1 or 5 (the data aliases) returns the register selected by the index. Both aliases return the same value.
- R4: A data write to an index above 7, or to any index while bit 7 of register 0x11 is clear, replaces the whole selected register.
- R5: While bit 7 of register 0x11 is set, data writes to indices 0 to 6 leave those registers unchanged.
- R6: While bit 7 of register 0x11 is set, a data write to index 7 copies bit 4 from `wdata_i` and keeps bits 7:5 and 3:0.
- R7: `upd_o` is high for exactly the one cycle after an accepted data write to an index in 0x00–0x07 or 0x10–0x18, and low otherwise. A write to index 7 under the lock counts as accepted.
- R8: Read data appears on `rdata_o` in the cycle after the read request. `rdata_o` is 0 in any cycle not preceded by a read of a mapped port. A read at an unmapped address (2, 3, 6, 7) returns 0. A write to an unmapped address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Port address: 0/4 index, 1/5 data |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, one cycle after the request |
| upd_o | output | 1 | Timing register update pulse |

## Verification
Every result is registered once. Index loads, register writes, read data and the update pulse therefore all become visible one clock edge after the request cycle. The bench drives each request on a falling edge and removes it on the next falling edge. It then checks `rdata_o` and `upd_o` at that second falling edge, which lies half a cycle after the edge that registered them. A behavioural model advances on each rising edge from the same inputs. It is compared at every falling edge, so a missing pulse, an extra pulse or a late pulse is caught in its exact cycle.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  typedef enum logic [1:0] {
    PORT_NONE  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2
  } port_e;
endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode
  import crtc_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int IDX_A0 = 0,
  parameter int DAT_A0 = 1,
  parameter int IDX_A1 = 4,
  parameter int DAT_A1 = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output port_e             port_o
);
  always_comb begin
    port_o = PORT_NONE;
    if (addr_i == ADDR_W'(IDX_A0) || addr_i == ADDR_W'(IDX_A1)) port_o = PORT_INDEX;
    else if (addr_i == ADDR_W'(DAT_A0) || addr_i == ADDR_W'(DAT_A1)) port_o = PORT_DATA;
  end
endmodule

// File: rtl/crtc_lock_filter.sv
module crtc_lock_filter #(
  parameter int DW        = 8,
  parameter int IW        = 8,
  parameter int PROT_LAST = 7,
  parameter int FREE_IDX  = 7,
  parameter int FREE_BIT  = 4
) (
  input  logic          wr_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] cur_i,
  input  logic          lock_i,
  output logic          we_o,
  output logic [DW-1:0] wval_o
);
  localparam logic [DW-1:0] FREE_MASK = DW'(1) << FREE_BIT;

  logic prot_hit;
  assign prot_hit = lock_i && (int'(idx_i) <= PROT_LAST);

  always_comb begin
    we_o   = wr_i;
    wval_o = wdata_i;
    if (prot_hit) begin
      if (int'(idx_i) == FREE_IDX) begin
        // only the exempt bit follows the bus
        wval_o = (cur_i & ~FREE_MASK) | (wdata_i & FREE_MASK);
      end else begin
        we_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile #(
  parameter int DW       = 8,
  parameter int IW       = 8,
  parameter int LOCK_IDX = 17,
  parameter int LOCK_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wval_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rval_o,
  output logic          lock_o
);
  localparam int DEPTH = 1 << IW;

  logic [DEPTH-1:0][DW-1:0] ents;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              q <= '0;
      else if (we_i && widx_i == IW'(g))        q <= wval_i;
    end
    assign ents[g] = q;
  end

  assign rval_o = ents[ridx_i];
  assign lock_o = ents[LOCK_IDX][LOCK_BIT];

  p_store_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ents[$past(widx_i)] == $past(wval_i));
endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DW        = 8,
  parameter int IW        = 8,
  parameter int LOCK_IDX  = 17,
  parameter int LOCK_BIT  = 7,
  parameter int PROT_LAST = 7,
  parameter int FREE_IDX  = 7,
  parameter int FREE_BIT  = 4,
  parameter int TA_LO     = 0,
  parameter int TA_HI     = 7,
  parameter int TB_LO     = 16,
  parameter int TB_HI     = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              upd_o
);
  localparam logic [DW-1:0] FREE_MASK = DW'(1) << FREE_BIT;

  port_e         port;
  logic [IW-1:0] idx_q;
  logic [DW-1:0] cur, wval, rd_next;
  logic          mem_we, locked, idx_wr, data_wr, tim_hit;

  crtc_port_decode #(.ADDR_W(ADDR_W)) i_dec (
    .addr_i (addr_i),
    .port_o (port)
  );

  assign idx_wr  = req_i && we_i && port == PORT_INDEX;
  assign data_wr = req_i && we_i && port == PORT_DATA;

  crtc_lock_filter #(
    .DW(DW), .IW(IW), .PROT_LAST(PROT_LAST), .FREE_IDX(FREE_IDX), .FREE_BIT(FREE_BIT)
  ) i_filt (
    .wr_i    (data_wr),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .cur_i   (cur),
    .lock_i  (locked),
    .we_o    (mem_we),
    .wval_o  (wval)
  );

  crtc_regfile #(.DW(DW), .IW(IW), .LOCK_IDX(LOCK_IDX), .LOCK_BIT(LOCK_BIT)) i_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .widx_i (idx_q),
    .wval_i (wval),
    .ridx_i (idx_q),
    .rval_o (cur),
    .lock_o (locked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_wr) idx_q <= IW'(wdata_i);
  end

  assign tim_hit = (int'(idx_q) >= TA_LO && int'(idx_q) <= TA_HI) ||
                   (int'(idx_q) >= TB_LO && int'(idx_q) <= TB_HI);

  always_comb begin
    rd_next = '0;
    if (req_i && !we_i) begin
      unique case (port)
        PORT_INDEX: rd_next = DW'(idx_q);
        PORT_DATA:  rd_next = cur;
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      upd_o   <= 1'b0;
    end else begin
      rdata_o <= rd_next;
      upd_o   <= mem_we && tim_hit;
    end
  end

  p_index_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr |=> idx_q == $past(IW'(wdata_i)));

  p_lock_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && locked && int'(idx_q) < FREE_IDX) |=> $stable(cur));

  p_free_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && locked && int'(idx_q) == FREE_IDX) |=>
      ((cur & ~FREE_MASK) == ($past(cur) & ~FREE_MASK)) &&
      ((cur & FREE_MASK) == ($past(wdata_i) & FREE_MASK)));

  p_upd_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(data_wr));

  p_rd_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i && !we_i) |-> rdata_o == '0);
endmodule

// File: tb/test_crtc_regs.sv
module test_crtc_regs;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       req = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       upd;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crtc_regs i_crtc_regs (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .upd_o(upd)
  );

  // behavioural reference model
  int mreg [256];
  int midx, exp_rd, exp_up;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (mreg[i]) mreg[i] = 0;
      midx = 0; exp_rd = 0; exp_up = 0;
    end else begin
      bit is_i, is_d, ok;
      is_i = (addr == 0 || addr == 4);
      is_d = (addr == 1 || addr == 5);
      ok = 0;
      exp_rd = 0; exp_up = 0;
      if (req && !we) begin
        if (is_i) exp_rd = midx;
        else if (is_d) exp_rd = mreg[midx];
      end else if (req && we) begin
        if (is_i) midx = wdata;
        else if (is_d) begin
          if (!mreg[17][7] || midx > 7) begin mreg[midx] = wdata; ok = 1; end
          else if (midx == 7) begin
            mreg[7] = (mreg[7] & 8'hEF) | (wdata & 8'h10); ok = 1;
          end
          if (ok && (midx <= 7 || (midx >= 16 && midx <= 24))) exp_up = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rdata !== 8'(exp_rd)) begin
        errors++;
        $display("FAIL R8 model rdata actual %02h expected %02h", rdata, exp_rd);
      end
      checks++;
      if (upd !== exp_up[0]) begin
        errors++;
        $display("FAIL R7 model upd actual %0b expected %0b", upd, exp_up);
      end
    end
  end

  task automatic op(input bit w, input int a, input int d);
    @(negedge clk);
    req = 1; we = w; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    op(0, a, 0);
    chk(tag, int'(rdata), exp);
  endtask

  task automatic wr_reg(input int idx, input int d, input int exp_upd, input string tag);
    op(1, 0, idx);
    op(1, 1, d);
    chk(tag, int'(upd), exp_upd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", int'(rdata), 0);
    chk("R1 upd", int'(upd), 0);
    rst_n = 1;
    rd(0, 8'h00, "R1 index");
    rd(1, 8'h00, "R1 reg0");
    op(1, 0, 8'h20);
    rd(4, 8'h20, "R2 index alias");
    wr_reg(8'h20, 8'hA5, 0, "R7 no pulse 0x20");
    rd(1, 8'hA5, "R3 data primary");
    rd(5, 8'hA5, "R3 data secondary");
    wr_reg(3, 8'h3C, 1, "R7 pulse idx3");
    @(negedge clk); chk("R7 pulse one cycle", int'(upd), 0);
    wr_reg(8'h18, 8'h11, 1, "R7 pulse 0x18");
    wr_reg(8'h19, 8'h11, 0, "R7 no pulse 0x19");
    wr_reg(8'h10, 8'h22, 1, "R7 pulse 0x10");
    wr_reg(8'h0F, 8'h22, 0, "R7 no pulse 0x0F");
    wr_reg(7, 8'hC3, 1, "R7 pulse idx7");
    rd(1, 8'hC3, "R4 unlocked replace");
    wr_reg(8'h11, 8'h80, 1, "R7 pulse lock reg");
    wr_reg(3, 8'hFF, 0, "R5 blocked no pulse");
    rd(1, 8'h3C, "R5 idx3 kept");
    wr_reg(0, 8'h55, 0, "R5 blocked idx0");
    rd(1, 8'h00, "R5 idx0 kept");
    wr_reg(7, 8'hFF, 1, "R6 pulse on exempt write");
    rd(1, 8'hD3, "R6 bit4 set");
    wr_reg(7, 8'h00, 1, "R6 pulse again");
    rd(1, 8'hC3, "R6 bit4 clear");
    wr_reg(8, 8'h99, 0, "R4 no pulse idx8");
    rd(5, 8'h99, "R4 idx8 under lock");
    rd(2, 8'h00, "R8 unmapped read");
    op(1, 3, 8'h44);
    op(1, 6, 8'h44);
    rd(0, 8'h08, "R8 unmapped write ignored");
    rd(1, 8'h99, "R8 reg kept after unmapped write");
    @(negedge clk); chk("R8 idle rdata", int'(rdata), 0);
    wr_reg(8'h11, 8'h00, 1, "R4 unlock");
    wr_reg(3, 8'h44, 1, "R4 write after unlock");
    rd(1, 8'h44, "R4 idx3 replaced");
    for (int i = 0; i < 256; i++) begin
      op(1, (i & 1) ? 4 : 0, i);
      op(1, (i & 1) ? 5 : 1, i ^ 8'h5A);
    end
    for (int i = 250; i < 256; i++) begin
      op(1, 0, i);
      rd(5, i ^ 8'h5A, "R4 sweep readback");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule